// File: doc/BRIEF.md
# Gated Disk Taskfile Register Window

This block is the host-facing register window of a disk controller. A simple host register bus (word address, write data, write and read strobes, registered read data) reaches the six byte-wide taskfile registers, the command and status pair, and a small set of DMA setup registers. The drive core supplies a busy flag, an error byte and a status byte. It receives the taskfile bytes and a one-cycle command strobe.

Access to the taskfile is gated by a key register. After reset the window is locked. Writing one magic word to the key register opens it, and writing a second magic word closes it again. While the window is locked, taskfile writes are dropped and taskfile reads return all ones. While the window is open, taskfile writes are still dropped when the drive reports busy. The only exception is the no-operation command, which is always passed through.

The DMA registers are never gated. A start write, made while the DMA enable register holds exactly 1, clears the transferred-size register and raises a request toward the data mover. The request carries the programmed address, length and direction. The mover answers with a done pulse and a byte count. The count is stored and the start register falls back to 0.

Top module: `tfw_top`

## Requirements
- R1: After reset, the window is locked, every taskfile output and DMA register is 0, and dmaReq, cmdValid and hostRdata are 0.
- R2: A write of 0x001FFFFF to the key register (address 14) opens the window and a write of 0x000042FE closes it. Every written value is stored and read back from address 14, and any other value leaves the lock state unchanged.
- R3: While the window is locked, writes to addresses 0 to 6 change nothing and raise no cmdValid. Reads of addresses 0 to 6 return 0xFFFFFFFF.
- R4: While the window is open and driveBusy is low, a write to address 0 (feature), 1 (count), 2, 3, 4 (address bytes, low to high) or 5 (device) stores the low 8 bits of the write data. The stored byte drives the matching tf output. Reads of addresses 1 to 5 return the stored byte, zero-extended.
- R5: While driveBusy is high, writes to addresses 0 to 5 are dropped.
- R6: While the window is open, a write to address 6 raises cmdValid for one cycle after the write edge, with cmdCode equal to the low data byte. This happens only when driveBusy is low or the code is the no-operation code 0x00. Otherwise cmdValid stays low.
- R7: A read registers its data on the edge that samples hostRd, and hostRdata holds between reads. Reads return the following: driveError from address 0, and driveStatus from address 6, both zero-extended when the window is open.
- R8: A write of 1 to address 12 while address 11 holds exactly 1 and no request is pending does three things. It sets address 13 to 0, raises dmaReq from the next cycle, and makes address 12 read 1. During the request, dmaAddr, dmaLen and dmaDir show the values of addresses 8, 9 and bit 0 of address 10.
- R9: A dmaDone pulse during a pending request stores dmaCount at address 13, drops dmaReq, and returns address 12 to 0, all on the same edge.
- R10: A write of 1 to address 12 while address 11 is not 1 raises no request. Address 12 reads 0 and address 13 keeps its value.
- R11: Addresses 8 to 13 can be written and read whether the window is locked or not.
- R12: Three things are ignored: writes to address 12 while a request is pending or with a value other than 1, writes to address 13, and dmaDone while no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 4 | Host word address |
| hostWdata | input | 32 | Host write data |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostRdata | output | 32 | Registered read data |
| driveBusy | input | 1 | Drive core busy flag |
| driveError | input | 8 | Drive error byte |
| driveStatus | input | 8 | Drive status byte |
| tfFeature | output | 8 | Stored feature byte |
| tfCount | output | 8 | Stored sector count byte |
| tfLbaLow | output | 8 | Stored address byte, low |
| tfLbaMid | output | 8 | Stored address byte, middle |
| tfLbaHigh | output | 8 | Stored address byte, high |
| tfDevice | output | 8 | Stored device byte |
| cmdValid | output | 1 | One-cycle command strobe to drive |
| cmdCode | output | 8 | Command code |
| dmaReq | output | 1 | Transfer request, held until done |
| dmaAddr | output | 32 | Programmed transfer address |
| dmaLen | output | 32 | Programmed transfer length |
| dmaDir | output | 1 | Programmed transfer direction |
| dmaDone | input | 1 | Transfer completion pulse |
| dmaCount | input | 32 | Bytes moved, valid with dmaDone |

## Verification
The bench goes after the lock boundary. It writes a non-magic key and checks that the window stays locked. A design that matched only some key bits would open early. The bench then issues commands while busy, both a non-zero code and the no-operation code. A design that gated every command on busy would never deliver the no-operation code, and one that ignored busy would strobe the non-zero code. The DMA checks do four things: they start with the enable register set to 2, they restart during a pending request, they send a done pulse while idle, and they read the size register mid-transfer. These catch a loose enable test, a reissued request that clears the count, and a stray count overwrite.

// File: rtl/tfw_pkg.sv
package tfw_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;
  localparam int TF_BYTES = 6;

  localparam logic [ADDR_W-1:0] A_FEAT     = 4'd0;
  localparam logic [ADDR_W-1:0] A_CMD      = 4'd6;
  localparam logic [ADDR_W-1:0] A_DMA_ADDR = 4'd8;
  localparam logic [ADDR_W-1:0] A_DMA_LEN  = 4'd9;
  localparam logic [ADDR_W-1:0] A_DMA_DIR  = 4'd10;
  localparam logic [ADDR_W-1:0] A_DMA_EN   = 4'd11;
  localparam logic [ADDR_W-1:0] A_DMA_GO   = 4'd12;
  localparam logic [ADDR_W-1:0] A_DMA_XFER = 4'd13;
  localparam logic [ADDR_W-1:0] A_KEY      = 4'd14;

  localparam logic [DATA_W-1:0] KEY_OPEN = 32'h001F_FFFF;
  localparam logic [DATA_W-1:0] KEY_SHUT = 32'h0000_42FE;
  localparam logic [BYTE_W-1:0] NOP_CODE = 8'h00;

  typedef struct packed {
    logic [TF_BYTES-1:0] wrTf;
    logic                wrCmd;
    logic                wrDmaAddr;
    logic                wrDmaLen;
    logic                wrDmaDir;
    logic                wrDmaEn;
    logic                wrKey;
    logic                dmaLaunch;
    logic                dmaFinish;
    logic                rdEn;
    logic                rdOnes;
  } tfw_strobe_t;
endpackage

// File: rtl/tfw_ctrl.sv
module tfw_ctrl
  import tfw_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NB = TF_BYTES
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] hostAddr,
  input  logic [DW-1:0] hostWdata,
  input  logic          hostWr,
  input  logic          hostRd,
  input  logic          driveBusy,
  input  logic          unlocked,
  input  logic          dmaArmed,
  input  logic          dmaDone,
  output tfw_strobe_t   strobes,
  output logic          dmaPending
);
  localparam logic [DW-1:0] GO_VALUE = DW'(1);

  logic [NB-1:0] tfHit;
  logic          isTaskfile;
  logic          launch;
  logic          finish;

  for (genvar i = 0; i < NB; i++) begin : g_tfHit
    assign tfHit[i] = hostWr && unlocked && !driveBusy && (hostAddr == AW'(i));
  end

  assign isTaskfile = (hostAddr <= A_CMD);
  assign launch = hostWr && (hostAddr == A_DMA_GO) && (hostWdata == GO_VALUE)
                  && dmaArmed && !dmaPending;
  assign finish = dmaPending && dmaDone;

  always_comb begin
    strobes           = '0;
    strobes.wrTf      = tfHit;
    strobes.wrCmd     = hostWr && unlocked && (hostAddr == A_CMD)
                        && (!driveBusy || (hostWdata[BYTE_W-1:0] == NOP_CODE));
    strobes.wrDmaAddr = hostWr && (hostAddr == A_DMA_ADDR);
    strobes.wrDmaLen  = hostWr && (hostAddr == A_DMA_LEN);
    strobes.wrDmaDir  = hostWr && (hostAddr == A_DMA_DIR);
    strobes.wrDmaEn   = hostWr && (hostAddr == A_DMA_EN);
    strobes.wrKey     = hostWr && (hostAddr == A_KEY);
    strobes.dmaLaunch = launch;
    strobes.dmaFinish = finish;
    strobes.rdEn      = hostRd;
    strobes.rdOnes    = isTaskfile && !unlocked;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dmaPending <= 1'b0;
    end else if (launch) begin
      dmaPending <= 1'b1;
    end else if (finish) begin
      dmaPending <= 1'b0;
    end
  end
endmodule

// File: rtl/tfw_datapath.sv
module tfw_datapath
  import tfw_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int BW = BYTE_W,
  parameter int NB = TF_BYTES
) (
  input  logic          clk,
  input  logic          rstN,
  input  tfw_strobe_t   strobes,
  input  logic [AW-1:0] hostAddr,
  input  logic [DW-1:0] hostWdata,
  input  logic [BW-1:0] driveError,
  input  logic [BW-1:0] driveStatus,
  input  logic          dmaPending,
  input  logic [DW-1:0] dmaCount,
  output logic [DW-1:0] hostRdata,
  output logic [BW-1:0] tfByte [NB],
  output logic          cmdValid,
  output logic [BW-1:0] cmdCode,
  output logic          unlocked,
  output logic          dmaArmed,
  output logic [DW-1:0] dmaAddr,
  output logic [DW-1:0] dmaLen,
  output logic          dmaDir
);
  logic [DW-1:0] keyReg;
  logic [DW-1:0] dmaEnReg;
  logic [DW-1:0] xferReg;
  logic [DW-1:0] rdNext;

  for (genvar i = 0; i < NB; i++) begin : g_tfReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tfByte[i] <= '0;
      end else if (strobes.wrTf[i]) begin
        tfByte[i] <= hostWdata[BW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdCode  <= '0;
    end else begin
      cmdValid <= strobes.wrCmd;
      if (strobes.wrCmd) begin
        cmdCode <= hostWdata[BW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyReg   <= '0;
      unlocked <= 1'b0;
    end else if (strobes.wrKey) begin
      keyReg <= hostWdata;
      if (hostWdata == KEY_OPEN) begin
        unlocked <= 1'b1;
      end else if (hostWdata == KEY_SHUT) begin
        unlocked <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dmaAddr  <= '0;
      dmaLen   <= '0;
      dmaDir   <= 1'b0;
      dmaEnReg <= '0;
    end else begin
      if (strobes.wrDmaAddr) dmaAddr  <= hostWdata;
      if (strobes.wrDmaLen)  dmaLen   <= hostWdata;
      if (strobes.wrDmaDir)  dmaDir   <= hostWdata[0];
      if (strobes.wrDmaEn)   dmaEnReg <= hostWdata;
    end
  end

  assign dmaArmed = (dmaEnReg == DW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xferReg <= '0;
    end else if (strobes.dmaLaunch) begin
      xferReg <= '0;
    end else if (strobes.dmaFinish) begin
      xferReg <= dmaCount;
    end
  end

  always_comb begin
    rdNext = '0;
    if (strobes.rdOnes) begin
      rdNext = '1;
    end else begin
      case (hostAddr)
        A_FEAT:     rdNext = DW'(driveError);
        4'd1:       rdNext = DW'(tfByte[1]);
        4'd2:       rdNext = DW'(tfByte[2]);
        4'd3:       rdNext = DW'(tfByte[3]);
        4'd4:       rdNext = DW'(tfByte[4]);
        4'd5:       rdNext = DW'(tfByte[5]);
        A_CMD:      rdNext = DW'(driveStatus);
        A_DMA_ADDR: rdNext = dmaAddr;
        A_DMA_LEN:  rdNext = dmaLen;
        A_DMA_DIR:  rdNext = DW'(dmaDir);
        A_DMA_EN:   rdNext = dmaEnReg;
        A_DMA_GO:   rdNext = DW'(dmaPending);
        A_DMA_XFER: rdNext = xferReg;
        A_KEY:      rdNext = keyReg;
        default:    rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRdata <= '0;
    end else if (strobes.rdEn) begin
      hostRdata <= rdNext;
    end
  end
endmodule

// File: rtl/tfw_top.sv
module tfw_top
  import tfw_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] hostAddr,
  input  logic [DW-1:0] hostWdata,
  input  logic          hostWr,
  input  logic          hostRd,
  output logic [DW-1:0] hostRdata,
  input  logic          driveBusy,
  input  logic [BW-1:0] driveError,
  input  logic [BW-1:0] driveStatus,
  output logic [BW-1:0] tfFeature,
  output logic [BW-1:0] tfCount,
  output logic [BW-1:0] tfLbaLow,
  output logic [BW-1:0] tfLbaMid,
  output logic [BW-1:0] tfLbaHigh,
  output logic [BW-1:0] tfDevice,
  output logic          cmdValid,
  output logic [BW-1:0] cmdCode,
  output logic          dmaReq,
  output logic [DW-1:0] dmaAddr,
  output logic [DW-1:0] dmaLen,
  output logic          dmaDir,
  input  logic          dmaDone,
  input  logic [DW-1:0] dmaCount
);
  tfw_strobe_t   strobes;
  logic          unlocked;
  logic          dmaArmed;
  logic          dmaPending;
  logic [BW-1:0] tfByte [TF_BYTES];

  tfw_ctrl #(.AW(AW), .DW(DW), .NB(TF_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostWr(hostWr), .hostRd(hostRd), .driveBusy(driveBusy),
    .unlocked(unlocked), .dmaArmed(dmaArmed), .dmaDone(dmaDone),
    .strobes(strobes), .dmaPending(dmaPending)
  );

  tfw_datapath #(.AW(AW), .DW(DW), .BW(BW), .NB(TF_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .driveError(driveError), .driveStatus(driveStatus),
    .dmaPending(dmaPending), .dmaCount(dmaCount), .hostRdata(hostRdata),
    .tfByte(tfByte), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .unlocked(unlocked), .dmaArmed(dmaArmed), .dmaAddr(dmaAddr),
    .dmaLen(dmaLen), .dmaDir(dmaDir)
  );

  assign tfFeature = tfByte[0];
  assign tfCount   = tfByte[1];
  assign tfLbaLow  = tfByte[2];
  assign tfLbaMid  = tfByte[3];
  assign tfLbaHigh = tfByte[4];
  assign tfDevice  = tfByte[5];
  assign dmaReq    = dmaPending;
endmodule

// File: rtl/tfw_checker.sv
module tfw_checker
  import tfw_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] hostAddr,
  input logic [DATA_W-1:0] hostWdata,
  input logic              hostWr,
  input logic              driveBusy,
  input logic              cmdValid,
  input logic [BYTE_W-1:0] cmdCode,
  input logic              dmaReq,
  input logic              dmaDone,
  input logic [BYTE_W-1:0] tfCount
);
  // R1: reset clears the strobes
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!cmdValid && !dmaReq));

  // R5: a busy cycle never changes a taskfile byte
  assert_busy_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    driveBusy |=> $stable(tfCount));

  // R6: each command strobe comes from a command write on the previous edge
  assert_cmd_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> ($past(hostWr) && ($past(hostAddr) == A_CMD)
                  && ($past(hostWdata[BYTE_W-1:0]) == cmdCode)));

  // R6: only the no-operation code passes a busy drive
  assert_cmd_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (!$past(driveBusy) || (cmdCode == NOP_CODE)));

  // R8: a request rises only after a start write of 1
  assert_req_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaReq) |-> $past(hostWr && (hostAddr == A_DMA_GO) && (hostWdata == 32'd1)));

  // R9: done retires the request
  assert_done_drops_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && dmaDone) |=> !dmaReq);
endmodule

bind tfw_top tfw_checker u_chk (
  .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWdata(hostWdata),
  .hostWr(hostWr), .driveBusy(driveBusy), .cmdValid(cmdValid),
  .cmdCode(cmdCode), .dmaReq(dmaReq), .dmaDone(dmaDone), .tfCount(tfCount)
);

// File: tb/tfw_top_bench.sv
module tfw_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic        hostWr = 1'b0;
  logic        hostRd = 1'b0;
  logic [31:0] hostRdata;
  logic        driveBusy = 1'b0;
  logic [7:0]  driveError = 8'h5A;
  logic [7:0]  driveStatus = 8'hC3;
  logic [7:0]  tfFeature, tfCount, tfLbaLow, tfLbaMid, tfLbaHigh, tfDevice;
  logic        cmdValid;
  logic [7:0]  cmdCode;
  logic        dmaReq;
  logic [31:0] dmaAddr, dmaLen;
  logic        dmaDir;
  logic        dmaDone = 1'b0;
  logic [31:0] dmaCount = '0;

  tfw_top u_tfw_top (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostWr(hostWr), .hostRd(hostRd), .hostRdata(hostRdata),
    .driveBusy(driveBusy), .driveError(driveError), .driveStatus(driveStatus),
    .tfFeature(tfFeature), .tfCount(tfCount), .tfLbaLow(tfLbaLow),
    .tfLbaMid(tfLbaMid), .tfLbaHigh(tfLbaHigh), .tfDevice(tfDevice),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .dmaReq(dmaReq),
    .dmaAddr(dmaAddr), .dmaLen(dmaLen), .dmaDir(dmaDir),
    .dmaDone(dmaDone), .dmaCount(dmaCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit          mOpen;
  logic [31:0] mKey, mDAddr, mDLen, mDEn, mXfer, mRdata;
  bit          mDir, mPend, mCmdValid;
  logic [7:0]  mCmdCode;
  logic [7:0]  mTf [6];

  function automatic logic [31:0] modelRead(input int a);
    if (a <= 6 && !mOpen) return 32'hFFFF_FFFF;
    case (a)
      0: return {24'd0, driveError};
      1, 2, 3, 4, 5: return {24'd0, mTf[a]};
      6: return {24'd0, driveStatus};
      8: return mDAddr;
      9: return mDLen;
      10: return {31'd0, mDir};
      11: return mDEn;
      12: return {31'd0, mPend};
      13: return mXfer;
      14: return mKey;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mOpen = 0; mKey = 0; mDAddr = 0; mDLen = 0; mDEn = 0; mXfer = 0;
      mRdata = 0; mDir = 0; mPend = 0; mCmdValid = 0; mCmdCode = 0;
      for (int i = 0; i < 6; i++) mTf[i] = 0;
    end else begin
      bit wasPend;
      int a;
      wasPend = mPend;
      a = int'(hostAddr);
      if (hostRd) mRdata = modelRead(a);
      mCmdValid = 0;
      if (wasPend && dmaDone) begin
        mXfer = dmaCount;
        mPend = 0;
      end
      if (hostWr) begin
        if (a <= 5) begin
          if (mOpen && !driveBusy) mTf[a] = hostWdata[7:0];
        end else if (a == 6) begin
          if (mOpen && (!driveBusy || hostWdata[7:0] == 8'h00)) begin
            mCmdValid = 1;
            mCmdCode = hostWdata[7:0];
          end
        end else if (a == 8) mDAddr = hostWdata;
        else if (a == 9) mDLen = hostWdata;
        else if (a == 10) mDir = hostWdata[0];
        else if (a == 11) mDEn = hostWdata;
        else if (a == 12) begin
          if (hostWdata == 32'd1 && mDEn == 32'd1 && !wasPend) begin
            mXfer = 0;
            mPend = 1;
          end
        end else if (a == 14) begin
          mKey = hostWdata;
          if (hostWdata == 32'h001F_FFFF) mOpen = 1;
          else if (hostWdata == 32'h0000_42FE) mOpen = 0;
        end
      end
    end
  end

  // Compare against the model on every cycle
  always @(negedge clk) begin
    check(tfFeature == mTf[0], "R4 tfFeature", {24'd0, tfFeature}, {24'd0, mTf[0]});
    check(tfCount == mTf[1], "R4 tfCount", {24'd0, tfCount}, {24'd0, mTf[1]});
    check(tfLbaLow == mTf[2], "R4 tfLbaLow", {24'd0, tfLbaLow}, {24'd0, mTf[2]});
    check(tfLbaMid == mTf[3], "R4 tfLbaMid", {24'd0, tfLbaMid}, {24'd0, mTf[3]});
    check(tfLbaHigh == mTf[4], "R4 tfLbaHigh", {24'd0, tfLbaHigh}, {24'd0, mTf[4]});
    check(tfDevice == mTf[5], "R4 tfDevice", {24'd0, tfDevice}, {24'd0, mTf[5]});
    check(cmdValid == mCmdValid, "R6 cmdValid", {31'd0, cmdValid}, {31'd0, mCmdValid});
    check(cmdCode == mCmdCode, "R6 cmdCode", {24'd0, cmdCode}, {24'd0, mCmdCode});
    check(dmaReq == mPend, "R8 dmaReq", {31'd0, dmaReq}, {31'd0, mPend});
    check(dmaAddr == mDAddr, "R8 dmaAddr", dmaAddr, mDAddr);
    check(dmaLen == mDLen, "R8 dmaLen", dmaLen, mDLen);
    check(dmaDir == mDir, "R8 dmaDir", {31'd0, dmaDir}, {31'd0, mDir});
    check(hostRdata == mRdata, "R7 hostRdata", hostRdata, mRdata);
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      summary();
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    hostRd = 1'b1; hostAddr = a;
    @(negedge clk);
    hostRd = 1'b0;
    check(hostRdata == exp, tag, hostRdata, exp);
  endtask

  task automatic done(input logic [31:0] c);
    @(negedge clk);
    dmaDone = 1'b1; dmaCount = c;
    @(negedge clk);
    dmaDone = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(hostRdata == 0 && !dmaReq && !cmdValid && tfCount == 0, "R1 reset outputs",
          {hostRdata[29:0], dmaReq, cmdValid}, 32'd0);
    rstN = 1'b1;

    // Locked window
    rd(4'd1, 32'hFFFF_FFFF, "R1 locked after reset");
    wr(4'd1, 32'h55);
    check(tfCount == 8'h00, "R3 locked write dropped", {24'd0, tfCount}, 32'd0);
    wr(4'd6, 32'hEC);
    check(!cmdValid, "R3 locked command dropped", {31'd0, cmdValid}, 32'd0);
    rd(4'd6, 32'hFFFF_FFFF, "R3 locked status read");

    // Key register
    wr(4'd14, 32'h001F_FFFE);
    rd(4'd14, 32'h001F_FFFE, "R2 key stored");
    rd(4'd0, 32'hFFFF_FFFF, "R2 near-miss key keeps lock");
    wr(4'd14, 32'h001F_FFFF);
    rd(4'd0, 32'h0000_005A, "R7 feature address reads error");
    rd(4'd6, 32'h0000_00C3, "R7 status read");
    wr(4'd14, 32'h0000_1234);
    rd(4'd6, 32'h0000_00C3, "R2 other value keeps window open");

    // Taskfile bytes
    wr(4'd0, 32'hABCD_EF12);
    check(tfFeature == 8'h12, "R4 feature low byte", {24'd0, tfFeature}, 32'h12);
    wr(4'd1, 32'h0000_01FF);
    wr(4'd2, 32'h11); wr(4'd3, 32'h22); wr(4'd4, 32'h33); wr(4'd5, 32'hE0);
    rd(4'd1, 32'h0000_00FF, "R4 count readback");
    rd(4'd4, 32'h0000_0033, "R4 high address byte readback");
    check(hostRdata == 32'h33, "R7 read data holds", hostRdata, 32'h33);

    // Busy drive
    driveBusy = 1'b1;
    wr(4'd2, 32'h99);
    check(tfLbaLow == 8'h11, "R5 busy write dropped", {24'd0, tfLbaLow}, 32'h11);
    wr(4'd6, 32'h20);
    check(!cmdValid, "R6 busy command dropped", {31'd0, cmdValid}, 32'd0);
    wr(4'd6, 32'h100);
    check(cmdValid && cmdCode == 8'h00, "R6 no-op passes busy", {23'd0, cmdValid, cmdCode}, 32'h100);
    @(negedge clk);
    check(!cmdValid, "R6 strobe lasts one cycle", {31'd0, cmdValid}, 32'd0);
    driveBusy = 1'b0;
    wr(4'd6, 32'hEC);
    check(cmdValid && cmdCode == 8'hEC, "R6 command when idle", {23'd0, cmdValid, cmdCode}, 32'h1EC);

    // DMA setup while window open
    wr(4'd8, 32'h0C00_0040); wr(4'd9, 32'h800); wr(4'd10, 32'h1);
    wr(4'd11, 32'd2);
    wr(4'd12, 32'd1);
    check(!dmaReq, "R10 start without enable", {31'd0, dmaReq}, 32'd0);
    rd(4'd12, 32'd0, "R10 start reads zero");
    wr(4'd11, 32'd1);
    wr(4'd12, 32'd3);
    check(!dmaReq, "R12 start value other than one", {31'd0, dmaReq}, 32'd0);
    wr(4'd12, 32'd1);
    check(dmaReq && dmaAddr == 32'h0C00_0040 && dmaLen == 32'h800 && dmaDir,
          "R8 request with programmed setup", {31'd0, dmaReq}, 32'd1);
    rd(4'd12, 32'd1, "R8 start reads one while pending");
    done(32'd1500);
    check(!dmaReq, "R9 done drops request", {31'd0, dmaReq}, 32'd0);
    rd(4'd13, 32'd1500, "R9 count stored");
    rd(4'd12, 32'd0, "R9 start back to zero");
    done(32'd7);
    rd(4'd13, 32'd1500, "R12 idle done ignored");
    wr(4'd13, 32'hDEAD);
    rd(4'd13, 32'd1500, "R12 size register write ignored");
    wr(4'd11, 32'd0);
    wr(4'd12, 32'd1);
    rd(4'd13, 32'd1500, "R10 size kept without enable");
    wr(4'd11, 32'd1);
    wr(4'd12, 32'd1);
    rd(4'd13, 32'd0, "R8 size cleared on start");
    wr(4'd12, 32'd1);
    done(32'd64);
    rd(4'd13, 32'd64, "R12 restart during request ignored");

    // Lock again, DMA registers still open
    wr(4'd14, 32'h0000_42FE);
    rd(4'd5, 32'hFFFF_FFFF, "R2 shut key locks");
    wr(4'd9, 32'h1234);
    rd(4'd9, 32'h1234, "R11 DMA length while locked");
    wr(4'd5, 32'hA0);
    check(tfDevice == 8'hE0, "R3 device write dropped when locked", {24'd0, tfDevice}, 32'hE0);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule